// File: doc/BRIEF.md
# Status Read and Software Poll Port

This block is the host-facing read/write port of an interrupt controller's status logic. It holds the small amount of state that decides what a host read returns. That state is which of the request or in-service registers is currently selected, whether special mask mode is on, and whether a software poll is armed. A host write with address bit 0 low and the command pattern in bits 4..3 updates that state. A host read then returns the selected register, the mask register, or an encoded poll word.

A poll command arms a one-shot acknowledge. The next chip-selected read returns the highest pending level, which is supplied by a neighbouring priority resolver as a level code plus a valid flag. In the same cycle the block emits a one-hot claim vector, and the neighbouring registers use it to set the in-service bit and clear the request bit. From the poll write until that read, the block raises a freeze output so that the request register holds still.

Top module: `stat_poll_port`

## Requirements
- R1: After reset the selection is the request register, special mask mode is off and the freeze output is low.
- R2: A command write is a write with `cs` high, `a0` low, bit 7 = 0, bit 4 = 0 and bit 3 = 1. Within it, bit 1 (read-register) = 1 with bit 0 = 0 selects the request register, and bit 1 = 1 with bit 0 = 1 selects the in-service register.
- R3: The selection persists across any number of reads, and a command write with bit 1 = 0 leaves it unchanged.
- R4: A read with `a0` high and no poll armed returns the mask register, whatever the selection.
- R5: A command write with bit 2 (poll) = 1 arms a poll. The next chip-selected read returns {flag=1 in the top bit, zeros, level code in the low bits}, and in that read cycle it drives `claim_o` high with `claim_vec_o` one-hot at the reported level.
- R6: When poll and read-register are written together, the following read returns the poll word, not a register. The selection is still updated.
- R7: `freeze_o` is high from the clock edge after a poll write until the end of the poll read. The poll is one-shot, so the read after it is an ordinary register read.
- R8: A poll read with no pending request returns all zeros, keeps `claim_o` low and drives `claim_vec_o` to zero.
- R9: Bit 6 = 1 with bit 5 = 1 sets special mask mode, and bit 6 = 1 with bit 5 = 0 clears it. With bit 6 = 0 the mode is unchanged.
- R10: Writes that are not command writes (`a0` high, or bits 4..3 not equal to 01) change neither the selection, the special mask mode nor the poll state. Reads without an armed poll never drive `claim_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select, active high |
| wr_en | input | 1 | Write strobe, one cycle |
| rd_en | input | 1 | Read strobe, one cycle |
| a0 | input | 1 | Address bit 0 |
| wdata | input | 8 | Write data |
| irr_i | input | NLEV | Request register from the request block |
| isr_i | input | NLEV | In-service register |
| imr_i | input | NLEV | Mask register |
| best_lvl_i | input | LVW | Highest pending level from the resolver |
| best_vld_i | input | 1 | Resolver has a pending level |
| rdata_o | output | NLEV | Read data, valid during the read cycle |
| claim_o | output | 1 | Software acknowledge pulse |
| claim_vec_o | output | NLEV | One-hot level being claimed |
| freeze_o | output | 1 | Hold request register still |
| smm_o | output | 1 | Special mask mode state |

## Verification
On every cycle the assertions check the following. A mask read outside a poll returns the mask. A poll read with a pending level produces a one-hot claim at that level and a set flag. A poll read without one produces nothing. Freeze always drops after the poll read, claims happen only during poll reads, and special mask mode moves only on a write with bit 6 set. Only the bench's scenarios can show that register selection persists and ignores read-register-clear commands, that poll and read-register written together yield a poll word and then the new selection, and the exact encoded poll word values.

// File: rtl/stat_poll_pkg.sv
package stat_poll_pkg;
  localparam int CMD_W = 8;
  // command-word bit positions
  localparam int B_RSEL = 0;
  localparam int B_RDREG = 1;
  localparam int B_POLL = 2;
  localparam int B_SMM = 5;
  localparam int B_ESMM = 6;
  typedef enum logic { SEL_REQ = 1'b0, SEL_SVC = 1'b1 } sel_e;
endpackage

// File: rtl/stat_cmd_dec.sv
module stat_cmd_dec
  import stat_poll_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs,
  input  logic             wr_en,
  input  logic             a0,
  input  logic [CMD_W-1:0] wdata,
  input  logic             poll_rd,
  output sel_e             sel_o,
  output logic             smm_o,
  output logic             poll_arm_o
);
  logic cmd_wr;
  assign cmd_wr = cs && wr_en && !a0 && !wdata[7] && (wdata[4:3] == 2'b01);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_o      <= SEL_REQ;
      smm_o      <= 1'b0;
      poll_arm_o <= 1'b0;
    end else begin
      if (cmd_wr && wdata[B_RDREG])
        sel_o <= wdata[B_RSEL] ? SEL_SVC : SEL_REQ;
      if (cmd_wr && wdata[B_ESMM])
        smm_o <= wdata[B_SMM];
      if (cmd_wr && wdata[B_POLL])
        poll_arm_o <= 1'b1;
      else if (poll_rd)
        poll_arm_o <= 1'b0;
    end
  end
endmodule

// File: rtl/stat_rd_mux.sv
module stat_rd_mux
  import stat_poll_pkg::*;
#(
  parameter int NLEV = 8,
  localparam int LVW = $clog2(NLEV)
) (
  input  logic            rd_act,
  input  logic            poll_rd,
  input  logic            a0,
  input  sel_e            sel,
  input  logic [NLEV-1:0] irr_i,
  input  logic [NLEV-1:0] isr_i,
  input  logic [NLEV-1:0] imr_i,
  input  logic [LVW-1:0]  best_lvl_i,
  input  logic            best_vld_i,
  output logic [NLEV-1:0] rdata_o,
  output logic            claim_o,
  output logic [NLEV-1:0] claim_vec_o
);
  function automatic logic [NLEV-1:0] f_poll_word(logic vld, logic [LVW-1:0] lvl);
    logic [NLEV-1:0] w;
    w = '0;
    if (vld) begin
      w[NLEV-1] = 1'b1;
      w[LVW-1:0] = lvl;
    end
    return w;
  endfunction

  function automatic logic [NLEV-1:0] f_onehot(logic [LVW-1:0] lvl);
    logic [NLEV-1:0] v;
    v = '0;
    v[lvl] = 1'b1;
    return v;
  endfunction

  assign claim_o     = poll_rd && best_vld_i;
  assign claim_vec_o = claim_o ? f_onehot(best_lvl_i) : '0;

  always_comb begin
    rdata_o = '0;
    if (poll_rd)               rdata_o = f_poll_word(best_vld_i, best_lvl_i);
    else if (rd_act && a0)     rdata_o = imr_i;
    else if (rd_act)           rdata_o = (sel == SEL_SVC) ? isr_i : irr_i;
  end
endmodule

// File: rtl/stat_poll_port.sv
module stat_poll_port
  import stat_poll_pkg::*;
#(
  parameter int NLEV = 8,
  localparam int LVW = $clog2(NLEV)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic             a0,
  input  logic [CMD_W-1:0] wdata,
  input  logic [NLEV-1:0]  irr_i,
  input  logic [NLEV-1:0]  isr_i,
  input  logic [NLEV-1:0]  imr_i,
  input  logic [LVW-1:0]   best_lvl_i,
  input  logic             best_vld_i,
  output logic [NLEV-1:0]  rdata_o,
  output logic             claim_o,
  output logic [NLEV-1:0]  claim_vec_o,
  output logic             freeze_o,
  output logic             smm_o
);
  sel_e sel;
  logic poll_arm;
  logic rd_act;
  logic poll_rd;

  assign rd_act   = cs && rd_en;
  assign poll_rd  = rd_act && poll_arm;
  assign freeze_o = poll_arm;

  stat_cmd_dec u_dec (
    .clk(clk), .rst_n(rst_n), .cs(cs), .wr_en(wr_en), .a0(a0),
    .wdata(wdata), .poll_rd(poll_rd),
    .sel_o(sel), .smm_o(smm_o), .poll_arm_o(poll_arm)
  );

  stat_rd_mux #(.NLEV(NLEV)) u_mux (
    .rd_act(rd_act), .poll_rd(poll_rd), .a0(a0), .sel(sel),
    .irr_i(irr_i), .isr_i(isr_i), .imr_i(imr_i),
    .best_lvl_i(best_lvl_i), .best_vld_i(best_vld_i),
    .rdata_o(rdata_o), .claim_o(claim_o), .claim_vec_o(claim_vec_o)
  );
endmodule

// File: rtl/stat_poll_port_chk.sv
module stat_poll_port_chk #(
  parameter int NLEV = 8,
  localparam int LVW = $clog2(NLEV)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cs,
  input logic            wr_en,
  input logic            rd_en,
  input logic            a0,
  input logic [7:0]      wdata,
  input logic [NLEV-1:0] imr_i,
  input logic [LVW-1:0]  best_lvl_i,
  input logic            best_vld_i,
  input logic [NLEV-1:0] rdata_o,
  input logic            claim_o,
  input logic [NLEV-1:0] claim_vec_o,
  input logic            freeze_o,
  input logic            smm_o
);
  logic poll_read;
  logic esmm_wr;
  assign poll_read = cs && rd_en && freeze_o;
  assign esmm_wr   = cs && wr_en && !a0 && !wdata[7] && (wdata[4:3] == 2'b01) && wdata[6];

  a_r4_mask_read: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rd_en && a0 && !freeze_o) |-> (rdata_o == imr_i));

  a_r5_claim_level: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_read && best_vld_i) |-> (claim_o && $onehot(claim_vec_o)
                                   && claim_vec_o[best_lvl_i] && rdata_o[NLEV-1]));

  a_r7_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_read && !wr_en) |=> !freeze_o);

  a_r8_empty_poll: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_read && !best_vld_i) |-> (!claim_o && claim_vec_o == '0 && rdata_o == '0));

  a_r9_smm_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !esmm_wr |=> $stable(smm_o));

  a_r10_claim_only_poll: assert property (@(posedge clk) disable iff (!rst_n)
    claim_o |-> poll_read);
endmodule

bind stat_poll_port stat_poll_port_chk #(.NLEV(NLEV)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .wr_en(wr_en), .rd_en(rd_en), .a0(a0),
  .wdata(wdata), .imr_i(imr_i), .best_lvl_i(best_lvl_i), .best_vld_i(best_vld_i),
  .rdata_o(rdata_o), .claim_o(claim_o), .claim_vec_o(claim_vec_o),
  .freeze_o(freeze_o), .smm_o(smm_o)
);

// File: tb/stat_poll_port_tb_top.sv
module stat_poll_port_tb_top;
  logic clk = 0, rst_n = 0, cs = 0, wr_en = 0, rd_en = 0, a0 = 0;
  logic [7:0] wdata = '0, irr = 8'h5A, isr = 8'hC3, imr = 8'h24;
  logic [2:0] lvl = '0;
  logic vld = 0;
  logic [7:0] rdata, cvec;
  logic claim, freeze, smm;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  stat_poll_port dut_i (
    .clk(clk), .rst_n(rst_n), .cs(cs), .wr_en(wr_en), .rd_en(rd_en), .a0(a0),
    .wdata(wdata), .irr_i(irr), .isr_i(isr), .imr_i(imr),
    .best_lvl_i(lvl), .best_vld_i(vld),
    .rdata_o(rdata), .claim_o(claim), .claim_vec_o(cvec),
    .freeze_o(freeze), .smm_o(smm)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic adr, logic [7:0] d);
    @(negedge clk); cs = 1; wr_en = 1; a0 = adr; wdata = d;
    @(negedge clk); cs = 0; wr_en = 0; a0 = 0; wdata = '0;
  endtask

  // read: checks data, claim pulse and claim vector mid-cycle
  task automatic rd(string req, logic adr, logic [7:0] exp_d, logic exp_c, logic [7:0] exp_v);
    @(negedge clk); cs = 1; rd_en = 1; a0 = adr;
    #5;
    check(req, rdata, exp_d);
    check(req, claim, exp_c);
    check(req, cvec, exp_v);
    @(negedge clk); cs = 0; rd_en = 0; a0 = 0;
  endtask

  task automatic t_reset;
    check("R1 smm", smm, 0);
    check("R1 freeze", freeze, 0);
    rd("R1 default selection", 0, 8'h5A, 0, 0);
  endtask

  task automatic t_select;
    wr(0, 8'h0B);
    rd("R2 service select", 0, 8'hC3, 0, 0);
    rd("R3 persists", 0, 8'hC3, 0, 0);
    wr(0, 8'h08);
    rd("R3 rdreg clear keeps", 0, 8'hC3, 0, 0);
    wr(0, 8'h0A);
    rd("R2 request select", 0, 8'h5A, 0, 0);
  endtask

  task automatic t_mask;
    rd("R4 mask with request sel", 1, 8'h24, 0, 0);
    wr(0, 8'h0B);
    rd("R4 mask with service sel", 1, 8'h24, 0, 0);
    wr(0, 8'h0A);
  endtask

  task automatic t_poll;
    vld = 1; lvl = 3'd5;
    wr(0, 8'h0C);
    check("R7 freeze after poll write", freeze, 1);
    rd("R5 poll word lvl5", 0, 8'h85, 1, 8'h20);
    check("R7 freeze dropped", freeze, 0);
    rd("R7 one-shot", 0, 8'h5A, 0, 0);
    lvl = 3'd0;
    wr(0, 8'h0C);
    rd("R5 poll word lvl0", 0, 8'h80, 1, 8'h01);
  endtask

  task automatic t_poll_rr;
    vld = 1; lvl = 3'd2;
    wr(0, 8'h0F);
    rd("R6 poll over rdreg", 0, 8'h82, 1, 8'h04);
    rd("R6 selection updated", 0, 8'hC3, 0, 0);
    lvl = 3'd7;
    wr(0, 8'h0C);
    rd("R6 poll over mask read", 1, 8'h87, 1, 8'h80);
    wr(0, 8'h0A);
  endtask

  task automatic t_poll_empty;
    vld = 0; lvl = 3'd6;
    wr(0, 8'h0C);
    rd("R8 empty poll", 0, 8'h00, 0, 8'h00);
    check("R8 freeze dropped", freeze, 0);
    rd("R8 next read normal", 0, 8'h5A, 0, 0);
  endtask

  task automatic t_smm;
    wr(0, 8'h68); check("R9 set", smm, 1);
    wr(0, 8'h28); check("R9 esmm0 hold set", smm, 1);
    wr(0, 8'h48); check("R9 clear", smm, 0);
    wr(0, 8'h28); check("R9 esmm0 hold clear", smm, 0);
  endtask

  task automatic t_ignore;
    wr(1, 8'h6F);
    check("R10 a0 write smm", smm, 0);
    check("R10 a0 write poll", freeze, 0);
    rd("R10 a0 write selection", 0, 8'h5A, 0, 0);
    wr(0, 8'h7F);
    check("R10 bit4 write smm", smm, 0);
    check("R10 bit4 write poll", freeze, 0);
    wr(0, 8'hEF);
    check("R10 bit7 write smm", smm, 0);
    vld = 1; lvl = 3'd4;
    rd("R10 no claim without poll", 0, 8'h5A, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_select();
    t_mask();
    t_poll();
    t_poll_rr();
    t_poll_empty();
    t_smm();
    t_ignore();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule